// File: doc/BRIEF.md
# Escaped Message Framer with Checksum

This block reads an outgoing message from an external buffer and sends it as an escaped byte stream over a serial link. A start strobe launches a frame. The block reads the buffered bytes through a combinational read port and drops buffer entry 0, which holds the length. It exchanges the first two header bytes, which carry the network function and the sequence number. It then sends the payload, a checksum byte and an end-of-message marker. Any byte that would collide with a framing code is sent as an escape byte followed by a modified copy of itself.

A separate hello request makes the block send a short version announcement in place of a message. This is used when the link comes up. The output is a byte stream with a valid/ready handshake. A one-cycle done pulse marks the end of each frame.

Top module: `msg_framer`

## Requirements
- R1: After reset, `tx_valid_o` and `done_o` are low, and `tx_valid_o` stays low while no frame is in progress.
- R2: With message length L (buffer entries 0..L-1), entry 0 is never sent. The payload is entries 1..L-1. When L <= 1 the payload is empty.
- R3: When L >= 3, entry 2 is sent before entry 1. All other entries follow in ascending order.
- R4: A payload or checksum byte equal to 0xA0, 0xA1 or 0xAA is sent as 0xAA followed by the byte with bit 4 set (0xB0, 0xB1, 0xBA). The escape pair takes two accepted output beats.
- R5: After the payload, the block sends a checksum equal to 256 minus the 8-bit sum of the unescaped payload bytes, modulo 256. This checksum is escaped as in R4.
- R6: A message frame ends with one unescaped 0xA0 after the checksum.
- R7: A hello request sends 0xFF, 0x01, 0xA1, with the last byte unescaped.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold their values into the next cycle.
- R9: `done_o` is high for exactly one cycle: the cycle after the final 0xA0 or 0xA1 of a frame is accepted.
- R10: A start or hello request that arrives while a frame is in progress is ignored. If both arrive together while idle, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a message frame (when idle) |
| hello_i | input | 1 | Launch a version announcement (when idle) |
| len_i | input | AW+1 | Message length, including the length entry; sampled at start |
| rd_addr_o | output | AW | Buffer read address |
| rd_data_i | input | 8 | Buffer read data, combinational from rd_addr_o |
| tx_data_o | output | 8 | Output byte |
| tx_valid_o | output | 1 | Output byte valid |
| tx_ready_i | input | 1 | Sink accepts the byte this cycle |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong read index or a wrong swap decision shows up as a wrong byte on `tx_data_o` in the same beat it is sent. A lost escape phase produces an escape byte that is not followed by a 0xB0/0xB1/0xBA beat, which is visible on the very next accepted beat. A bad checksum accumulator is only visible in the last data beat before the terminator, so every frame is compared byte for byte, including a case whose checksum is itself a framing code. A sequencer stuck busy shows up as a missing done pulse one cycle after the terminator, or as a request that should be ignored launching a second frame.

// File: rtl/mf_pkg.sv
package mf_pkg;
  localparam logic [7:0] MF_EOM  = 8'hA0;
  localparam logic [7:0] MF_EOC  = 8'hA1;
  localparam logic [7:0] MF_ESC  = 8'hAA;
  localparam logic [7:0] MF_FLIP = 8'h10;
  localparam logic [7:0] MF_VCMD = 8'hFF;
  localparam logic [7:0] MF_VNUM = 8'h01;

  typedef enum logic [2:0] {
    S_IDLE, S_PAY, S_SUM, S_EOM, S_V0, S_V1, S_VEND
  } mf_state_e;

  function automatic logic is_reserved(input logic [7:0] b);
    return (b == MF_EOM) || (b == MF_EOC) || (b == MF_ESC);
  endfunction

  function automatic logic [7:0] sum_add(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  function automatic logic [7:0] sum_close(input logic [7:0] acc);
    return (~acc) + 8'd1;
  endfunction
endpackage

// File: rtl/mf_seq.sv
module mf_seq #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          hello_i,
  input  logic [AW:0]   len_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic [7:0]    lb_data_o,
  output logic          lb_raw_o,
  output logic          lb_valid_o,
  input  logic          lb_ready_i,
  output logic          busy_o,
  output logic          pay_o,
  output logic          term_acc_o
);
  import mf_pkg::*;

  localparam logic [AW:0] ONE   = (AW+1)'(1);
  localparam logic [AW:0] TWO   = (AW+1)'(2);
  localparam logic [AW:0] THREE = (AW+1)'(3);

  mf_state_e   st;
  logic [AW:0] idx, len_q, src;
  logic [7:0]  acc;
  logic        fire;

  assign fire = lb_valid_o && lb_ready_i;

  always_comb begin
    src = idx;
    if (len_q >= THREE) begin
      if (idx == ONE)      src = TWO;
      else if (idx == TWO) src = ONE;
    end
  end

  assign rd_addr_o = (st == S_PAY) ? src[AW-1:0] : '0;

  always_comb begin
    lb_data_o = 8'h00;
    lb_raw_o  = 1'b0;
    unique case (st)
      S_PAY:  lb_data_o = rd_data_i;
      S_SUM:  lb_data_o = sum_close(acc);
      S_EOM:  begin lb_data_o = MF_EOM; lb_raw_o = 1'b1; end
      S_V0:   lb_data_o = MF_VCMD;
      S_V1:   lb_data_o = MF_VNUM;
      S_VEND: begin lb_data_o = MF_EOC; lb_raw_o = 1'b1; end
      default: ;
    endcase
  end

  assign lb_valid_o = (st != S_IDLE);
  assign busy_o     = (st != S_IDLE);
  assign pay_o      = (st == S_PAY);
  assign term_acc_o = fire && lb_raw_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      idx   <= '0;
      len_q <= '0;
      acc   <= 8'h00;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (start_i) begin
            len_q <= len_i;
            idx   <= ONE;
            acc   <= 8'h00;
            st    <= (len_i > ONE) ? S_PAY : S_SUM;
          end else if (hello_i) begin
            st <= S_V0;
          end
        end
        S_PAY: if (fire) begin
          acc <= sum_add(acc, rd_data_i);
          if (idx == len_q - ONE) st <= S_SUM;
          else                    idx <= idx + ONE;
        end
        S_SUM:  if (fire) st <= S_EOM;
        S_EOM:  if (fire) st <= S_IDLE;
        S_V0:   if (fire) st <= S_V1;
        S_V1:   if (fire) st <= S_VEND;
        S_VEND: if (fire) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mf_stuff.sv
module mf_stuff (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] lb_data_i,
  input  logic       lb_raw_i,
  input  logic       lb_valid_i,
  output logic       lb_ready_o,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic       esc_phase_o
);
  import mf_pkg::*;

  logic second, needs_esc;

  assign needs_esc   = lb_valid_i && !lb_raw_i && is_reserved(lb_data_i);
  assign tx_valid_o  = lb_valid_i;
  assign tx_data_o   = second ? (lb_data_i | MF_FLIP) : (needs_esc ? MF_ESC : lb_data_i);
  assign lb_ready_o  = tx_ready_i && (second || !needs_esc);
  assign esc_phase_o = second;

  always_ff @(posedge clk) begin
    if (!rst_n)                                 second <= 1'b0;
    else if (tx_ready_i && needs_esc && !second) second <= 1'b1;
    else if (tx_ready_i && second)               second <= 1'b0;
  end
endmodule

// File: rtl/msg_framer.sv
module msg_framer #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          hello_i,
  input  logic [AW:0]   len_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic          done_o
);
  logic [7:0] lb_data;
  logic       lb_raw, lb_valid, lb_ready;
  logic       seq_busy, seq_pay, term_acc, esc_phase;

  mf_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hello_i(hello_i),
    .len_i(len_i), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .lb_data_o(lb_data), .lb_raw_o(lb_raw), .lb_valid_o(lb_valid),
    .lb_ready_i(lb_ready), .busy_o(seq_busy), .pay_o(seq_pay),
    .term_acc_o(term_acc)
  );

  mf_stuff u_stuff (
    .clk(clk), .rst_n(rst_n), .lb_data_i(lb_data), .lb_raw_i(lb_raw),
    .lb_valid_i(lb_valid), .lb_ready_o(lb_ready), .tx_data_o(tx_data_o),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .esc_phase_o(esc_phase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= term_acc;
  end
endmodule

// File: rtl/msg_framer_chk.sv
module msg_framer_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    tx_data_o,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic          done_o,
  input logic          seq_busy,
  input logic          seq_pay,
  input logic          esc_phase,
  input logic [AW-1:0] rd_addr_o
);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> !tx_valid_o);

  p_skip_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_pay |-> rd_addr_o != '0);

  p_esc_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && tx_ready_i && tx_data_o == 8'hAA) |=>
      (tx_valid_o && esc_phase &&
       (tx_data_o == 8'hB0 || tx_data_o == 8'hB1 || tx_data_o == 8'hBA)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(tx_valid_o && tx_ready_i &&
                     (tx_data_o == 8'hA0 || tx_data_o == 8'hA1)));
endmodule

bind msg_framer msg_framer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i), .done_o(done_o), .seq_busy(seq_busy),
  .seq_pay(seq_pay), .esc_phase(esc_phase), .rd_addr_o(rd_addr_o)
);

// File: tb/sim_msg_framer.sv
module sim_msg_framer;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, hello_i = 1'b0;
  logic [AW:0]   len_i = '0;
  logic [AW-1:0] rd_addr_o;
  logic [7:0]    rd_data_i;
  logic [7:0]    tx_data_o;
  logic          tx_valid_o;
  logic          tx_ready_i = 1'b0;
  logic          done_o;

  always #10 clk = ~clk;

  msg_framer #(.AW(AW)) u0 (.*);

  logic [7:0] mem [DEPTH];
  assign rd_data_i = mem[rd_addr_o];

  int tests = 0, fails = 0;
  int ready_mode = 0;
  int cyc = 0;
  logic [7:0] lfsr = 8'h5A;

  logic [7:0] got [128];
  logic [7:0] exp [128];
  int ng = 0, ne = 0;
  logic done_exp = 1'b0;
  int done_bad = 0, hold_bad = 0;
  logic was_stall = 1'b0;
  logic [7:0] stall_data = 8'h00;

  // ready driver, 1 ns after each rising edge
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (ready_mode)
      0: tx_ready_i = 1'b1;
      1: tx_ready_i = lfsr[0];
      default: tx_ready_i = (cyc % 3) == 0;
    endcase
  end

  // monitor at falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o !== done_exp) done_bad++;
      if (was_stall && (!tx_valid_o || tx_data_o !== stall_data)) hold_bad++;
      was_stall  = tx_valid_o && !tx_ready_i;
      stall_data = tx_data_o;
      done_exp = tx_valid_o && tx_ready_i && (tx_data_o == 8'hA0 || tx_data_o == 8'hA1);
      if (tx_valid_o && tx_ready_i && ng < 128) begin
        got[ng] = tx_data_o;
        ng++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic put_exp(input logic [7:0] b, input bit allow_esc);
    if (allow_esc && (b == 8'hA0 || b == 8'hA1 || b == 8'hAA)) begin
      exp[ne] = 8'hAA; ne++;
      exp[ne] = b + 8'h10; ne++;
    end else begin
      exp[ne] = b; ne++;
    end
  endtask

  task automatic build_msg(input int len);
    int order [DEPTH];
    int n = 0;
    int total = 0;
    ne = 0;
    for (int p = 1; p < len; p++) begin order[n] = p; n++; end
    if (n >= 2) begin order[0] = 2; order[1] = 1; end
    for (int k = 0; k < n; k++) begin
      put_exp(mem[order[k]], 1'b1);
      total += int'(mem[order[k]]);
    end
    put_exp(8'((256 - (total % 256)) % 256), 1'b1);
    put_exp(8'hA0, 1'b0);
  endtask

  task automatic build_hello();
    ne = 0;
    put_exp(8'hFF, 1'b0); put_exp(8'h01, 1'b0); put_exp(8'hA1, 1'b0);
  endtask

  task automatic wait_done(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (done_o) seen = 1'b1;
    end
    check(seen, tag, 0, 1);
  endtask

  task automatic compare(input string tag);
    bit ok = (ng == ne);
    int first = -1;
    for (int k = 0; k < ne && k < ng; k++)
      if (got[k] !== exp[k] && first < 0) first = k;
    if (first >= 0) ok = 1'b0;
    if (first >= 0) check(ok, tag, int'(got[first]), int'(exp[first]));
    else            check(ok, tag, ng, ne);
  endtask

  task automatic pulse(input bit s, input bit h);
    @(posedge clk); #2;
    start_i = s; hello_i = h;
    @(posedge clk); #2;
    start_i = 1'b0; hello_i = 1'b0;
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int i = 0; i < DEPTH; i++) mem[i] = seed + 8'(i * 29);
    if (seed[0]) begin mem[3] = 8'hA0; mem[4] = 8'hAA; mem[5] = 8'hA1; end
  endtask

  // {len, seed, ready mode}
  localparam logic [23:0] VEC [6] = '{
    {8'd32, 8'h11, 8'd1},
    {8'd3,  8'h40, 8'd0},
    {8'd8,  8'h23, 8'd2},
    {8'd1,  8'h05, 8'd0},
    {8'd12, 8'h77, 8'd1},
    {8'd6,  8'h09, 8'd0}
  };

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(tx_valid_o === 1'b0 && done_o === 1'b0, "R1 reset outputs", tx_valid_o, 0);

    // vector table: R2 R3 R4 R5 R6 R8
    foreach (VEC[v]) begin
      fill(VEC[v][15:8]);
      ready_mode = int'(VEC[v][7:0]);
      len_i = (AW+1)'(VEC[v][23:16]);
      build_msg(int'(VEC[v][23:16]));
      ng = 0;
      pulse(1'b1, 1'b0);
      wait_done("R9 frame done");
      compare("R2/R3/R4/R5/R6 frame bytes");
    end

    // checksum that is itself reserved, two-entry message: R5 R3
    ready_mode = 0;
    mem[0] = 8'h02; mem[1] = 8'h5F; len_i = (AW+1)'(2);
    build_msg(2);
    ng = 0; pulse(1'b1, 1'b0); wait_done("R5 done");
    compare("R5 escaped checksum");
    check(ne == 4 && exp[1] == 8'hAA && exp[2] == 8'hB1, "R5 expectation", ne, 4);

    // hello sequence: R7
    ready_mode = 2;
    build_hello();
    ng = 0; pulse(1'b0, 1'b1); wait_done("R7 done");
    compare("R7 version bytes");

    // start and hello together: start wins, R10
    ready_mode = 0;
    fill(8'h31); len_i = (AW+1)'(5);
    build_msg(5);
    ng = 0; pulse(1'b1, 1'b1); wait_done("R10 done");
    compare("R10 start priority");

    // requests while busy are ignored: R10
    ready_mode = 1;
    fill(8'h51); len_i = (AW+1)'(10);
    build_msg(10);
    ng = 0; pulse(1'b1, 1'b0);
    repeat (4) @(posedge clk);
    #2 len_i = (AW+1)'(3);
    pulse(1'b1, 1'b1);
    wait_done("R10 busy done");
    compare("R10 busy request ignored");
    ng = 0;
    repeat (20) @(negedge clk);
    check(ng == 0 && tx_valid_o === 1'b0, "R10 no second frame", ng, 0);
    check(tx_valid_o === 1'b0, "R1 idle quiet", tx_valid_o, 0);

    check(done_bad == 0, "R9 done timing", done_bad, 0);
    check(hold_bad == 0, "R8 hold under backpressure", hold_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule